// File: doc/BRIEF.md
# Flash Unlock Command Sequence Decoder

This block is the command interpreter on the device side of a parallel x16 NOR-style flash. Each host bus write reaches it as an address and data pair, already synchronised into the core clock domain and marked by a one-cycle `wr_valid_i`. The decoder follows the multi-cycle unlock grammar of the flash. When a program or erase sequence completes, it issues a one-cycle start pulse to the internal operation engine, together with the operation type, the target address and the program data.

The decoder also holds the read mode. The mode is array read, identification or query. In the two non-array modes the block supplies the word to return for the current read address: the manufacturer code, the device code, or an entry of a small geometry table that is computed from the parameters. While the engine reports that it is busy, every host write is discarded. Only address bits 14..0 and data bits 7..0 take part in command matching.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `rd_mode_o` is 0 (array read), `op_start_o` is 0, `op_type_o` is 0 and the sequence position is at its first step.
- R2: Only address bits 14..0 and data bits 7..0 are compared against command values. Every sequence opens with 0xAA written to 0x5555, followed by 0x55 written to 0x2AAA. Upper address and data bits never change the outcome.
- R3: After the two unlock writes, 0xA0 at 0x5555 arms programming. The next write of any address or data raises `op_start_o` for one cycle in the cycle after that write. It comes with `op_type_o`=1, `op_addr_o` equal to the full write address and `op_data_o` equal to the full write data.
- R4: Unlock, 0x80 at 0x5555, unlock again, then 0x10 at 0x5555 starts a chip erase: `op_type_o`=4 and `op_addr_o`=0.
- R5: The same five writes followed by 0x30 at any address start a sector erase: `op_type_o`=2, and `op_addr_o` is the write address with bits 10..0 cleared.
- R6: The same five writes followed by 0x50 at any address start a block erase: `op_type_o`=3, and `op_addr_o` is the write address with bits 14..0 cleared.
- R7: Unlock then 0x90 at 0x5555 sets `rd_mode_o`=1. In that mode `info_data_o` is MFR_CODE for read address 0, DEV_CODE for read address 1, and 0 for any other address.
- R8: Unlock then 0x98 at 0x5555 sets `rd_mode_o`=2. In that mode `info_data_o` is indexed by the read address. Offsets 0x10, 0x11 and 0x12 give 0x0051, 0x0052 and 0x0059. Offsets 0x13 and 0x28 give 1, 0x2C gives 2, and 0x27 gives address width plus one (0x15). Offsets 0x2D and 0x2E give the low and high byte of the sector count minus one (0xFF, 0x01). Offsets 0x2F and 0x30 give the sector size in 256-byte units (0x10, 0x00). Offsets 0x31 to 0x34 give the same two fields for blocks (0x1F, 0x00, 0x00, 0x01). Every other offset gives 0. In array mode `info_data_o` is 0.
- R9: A single write of 0xF0 to any address at the first step returns the mode to array. So does unlock followed by 0xF0 at 0x5555.
- R10: A write that does not match the step expected by the sequence returns the decoder to its first step and to array mode, and starts nothing.
- R11: While `busy_i` is high, writes have no effect. This covers the exit command: mode and sequence position stay unchanged and no start is issued.
- R12: `op_start_o` is never high on two consecutive cycles. Whenever `op_start_o` is low, `op_type_o`, `op_addr_o` and `op_data_o` are 0.
- R13: Issuing any start returns the read mode to array.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | One-cycle strobe for a host write |
| wr_addr_i | input | ADDR_W | Word address of the host write |
| wr_data_i | input | DATA_W | Data of the host write |
| busy_i | input | 1 | Operation engine is running |
| rd_addr_i | input | ADDR_W | Current host read address |
| op_start_o | output | 1 | One-cycle start to the operation engine |
| op_type_o | output | 3 | 1 program, 2 sector erase, 3 block erase, 4 chip erase |
| op_addr_o | output | ADDR_W | Target address, aligned for erases |
| op_data_o | output | DATA_W | Program data |
| rd_mode_o | output | 2 | 0 array, 1 identification, 2 query |
| info_data_o | output | DATA_W | Identification or query word for rd_addr_i |

## Verification
The bench drives sequences whose upper address and data bits are set. A decoder that compares the full bus would then refuse to unlock. It also breaks sequences at every step, including a sixth cycle with the chip-erase code at the wrong address. A decoder that forgets to abort would then start an erase or leave identification mode active. Exit commands are sent while `busy_i` is high and again after it falls, which exposes a decoder that leaves a mode during an operation. Sector and block erase targets use addresses with low bits set, so a wrong alignment mask appears on `op_addr_o`.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int CMP_AW = 15;
  localparam logic [CMP_AW-1:0] CMD_ADDR_A = 15'h5555;
  localparam logic [CMP_AW-1:0] CMD_ADDR_B = 15'h2AAA;

  localparam logic [7:0] CODE_UNLOCK_A = 8'hAA;
  localparam logic [7:0] CODE_UNLOCK_B = 8'h55;
  localparam logic [7:0] CODE_PROG     = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_IDENT    = 8'h90;
  localparam logic [7:0] CODE_QUERY    = 8'h98;
  localparam logic [7:0] CODE_EXIT     = 8'hF0;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_SECT     = 8'h30;
  localparam logic [7:0] CODE_BLOCK    = 8'h50;

  typedef enum logic [1:0] {
    RD_ARRAY = 2'd0,
    RD_IDENT = 2'd1,
    RD_QUERY = 2'd2
  } rd_mode_e;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_PROG  = 3'd1,
    OP_SECT  = 3'd2,
    OP_BLOCK = 3'd3,
    OP_CHIP  = 3'd4
  } op_type_e;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PROG,
    SEQ_ERS3,
    SEQ_ERS4,
    SEQ_ERS5
  } seq_state_e;

  // classification of one write cycle
  typedef struct packed {
    logic at_a;
    logic at_b;
    logic d_unl_a;
    logic d_unl_b;
    logic d_prog;
    logic d_erase;
    logic d_ident;
    logic d_query;
    logic d_exit;
    logic d_chip;
    logic d_sect;
    logic d_block;
  } cyc_class_t;

endpackage

// File: rtl/flash_cmd_match.sv
module flash_cmd_match
  import flash_cmd_pkg::*;
(
  input  logic [CMP_AW-1:0] addr_lo_i,
  input  logic [7:0]        data_lo_i,
  output cyc_class_t        cls_o
);

  always_comb begin
    cls_o.at_a    = (addr_lo_i == CMD_ADDR_A);
    cls_o.at_b    = (addr_lo_i == CMD_ADDR_B);
    cls_o.d_unl_a = (data_lo_i == CODE_UNLOCK_A);
    cls_o.d_unl_b = (data_lo_i == CODE_UNLOCK_B);
    cls_o.d_prog  = (data_lo_i == CODE_PROG);
    cls_o.d_erase = (data_lo_i == CODE_ERASE);
    cls_o.d_ident = (data_lo_i == CODE_IDENT);
    cls_o.d_query = (data_lo_i == CODE_QUERY);
    cls_o.d_exit  = (data_lo_i == CODE_EXIT);
    cls_o.d_chip  = (data_lo_i == CODE_CHIP);
    cls_o.d_sect  = (data_lo_i == CODE_SECT);
    cls_o.d_block = (data_lo_i == CODE_BLOCK);
  end

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SECTOR_LSB = 11,
  parameter int BLOCK_LSB  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic              busy_i,
  input  cyc_class_t        cls_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              op_start_o,
  output op_type_e          op_type_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output rd_mode_e          rd_mode_o
);

  localparam logic [ADDR_W-1:0] SECT_MASK = {ADDR_W{1'b1}} << SECTOR_LSB;
  localparam logic [ADDR_W-1:0] BLK_MASK  = {ADDR_W{1'b1}} << BLOCK_LSB;

  seq_state_e        st_q, st_d;
  rd_mode_e          mode_q, mode_d;
  logic              start_q, start_d;
  op_type_e          type_q, type_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              take, abort;

  assign take = wr_valid_i && !busy_i;

  always_comb begin
    st_d    = st_q;
    mode_d  = mode_q;
    start_d = 1'b0;
    type_d  = OP_NONE;
    addr_d  = '0;
    data_d  = '0;
    abort   = 1'b0;
    if (take) begin
      unique case (st_q)
        SEQ_IDLE: begin
          if (cls_i.d_exit)                    mode_d = RD_ARRAY;
          else if (cls_i.d_unl_a && cls_i.at_a) st_d = SEQ_UNL1;
          else                                  abort = 1'b1;
        end
        SEQ_UNL1: begin
          if (cls_i.d_unl_b && cls_i.at_b) st_d = SEQ_UNL2;
          else                             abort = 1'b1;
        end
        SEQ_UNL2: begin
          st_d = SEQ_IDLE;
          if (!cls_i.at_a)        abort = 1'b1;
          else if (cls_i.d_prog)  st_d = SEQ_PROG;
          else if (cls_i.d_erase) st_d = SEQ_ERS3;
          else if (cls_i.d_ident) mode_d = RD_IDENT;
          else if (cls_i.d_query) mode_d = RD_QUERY;
          else if (cls_i.d_exit)  mode_d = RD_ARRAY;
          else                    abort = 1'b1;
        end
        SEQ_PROG: begin
          st_d    = SEQ_IDLE;
          mode_d  = RD_ARRAY;
          start_d = 1'b1;
          type_d  = OP_PROG;
          addr_d  = wr_addr_i;
          data_d  = wr_data_i;
        end
        SEQ_ERS3: begin
          if (cls_i.d_unl_a && cls_i.at_a) st_d = SEQ_ERS4;
          else                             abort = 1'b1;
        end
        SEQ_ERS4: begin
          if (cls_i.d_unl_b && cls_i.at_b) st_d = SEQ_ERS5;
          else                             abort = 1'b1;
        end
        SEQ_ERS5: begin
          st_d   = SEQ_IDLE;
          mode_d = RD_ARRAY;
          if (cls_i.d_chip && cls_i.at_a) begin
            start_d = 1'b1;
            type_d  = OP_CHIP;
          end else if (cls_i.d_sect) begin
            start_d = 1'b1;
            type_d  = OP_SECT;
            addr_d  = wr_addr_i & SECT_MASK;
          end else if (cls_i.d_block) begin
            start_d = 1'b1;
            type_d  = OP_BLOCK;
            addr_d  = wr_addr_i & BLK_MASK;
          end
        end
        default: abort = 1'b1;
      endcase
      if (abort) begin
        st_d   = SEQ_IDLE;
        mode_d = RD_ARRAY;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= SEQ_IDLE;
      mode_q  <= RD_ARRAY;
      start_q <= 1'b0;
      type_q  <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      st_q    <= st_d;
      mode_q  <= mode_d;
      start_q <= start_d;
      type_q  <= type_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign op_start_o = start_q;
  assign op_type_o  = type_q;
  assign op_addr_o  = addr_q;
  assign op_data_o  = data_q;
  assign rd_mode_o  = mode_q;

  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && busy_i) |=> ($stable(st_q) && $stable(mode_q) && !start_q));

  // R12
  start_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q);

  // R12
  quiet_fields_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_q |-> (type_q == OP_NONE && addr_q == '0 && data_q == '0));

  // R10
  no_write_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_i |=> ($stable(st_q) && $stable(mode_q) && !start_q));

  // R3
  start_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> ($past(st_q) == SEQ_PROG || $past(st_q) == SEQ_ERS5));

  // R5
  sect_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_q && type_q == OP_SECT) |-> (addr_q[SECTOR_LSB-1:0] == '0));

  // R13
  start_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> (mode_q == RD_ARRAY));

endmodule

// File: rtl/flash_info_rom.sv
module flash_info_rom
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          DATA_W     = 16,
  parameter int          SECTOR_LSB = 11,
  parameter int          BLOCK_LSB  = 15,
  parameter logic [15:0] MFR_CODE   = 16'h00A7,
  parameter logic [15:0] DEV_CODE   = 16'h3C19
) (
  input  rd_mode_e          rd_mode_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] info_data_o
);

  localparam logic [15:0] SECT_CNT_M1 = 16'((1 << (ADDR_W - SECTOR_LSB)) - 1);
  localparam logic [15:0] BLK_CNT_M1  = 16'((1 << (ADDR_W - BLOCK_LSB)) - 1);
  localparam logic [15:0] SECT_UNITS  = 16'((1 << (SECTOR_LSB + 1)) / 256);
  localparam logic [15:0] BLK_UNITS   = 16'((1 << (BLOCK_LSB + 1)) / 256);
  localparam logic [15:0] SIZE_LOG2   = 16'(ADDR_W + 1);

  logic [15:0] qry_word;
  logic        low_page;

  assign low_page = (rd_addr_i[ADDR_W-1:8] == '0);

  always_comb begin
    qry_word = 16'h0000;
    if (low_page) begin
      unique case (rd_addr_i[7:0])
        8'h10:   qry_word = 16'h0051;
        8'h11:   qry_word = 16'h0052;
        8'h12:   qry_word = 16'h0059;
        8'h13:   qry_word = 16'h0001;
        8'h27:   qry_word = SIZE_LOG2;
        8'h28:   qry_word = 16'h0001;
        8'h2C:   qry_word = 16'h0002;
        8'h2D:   qry_word = {8'h00, SECT_CNT_M1[7:0]};
        8'h2E:   qry_word = {8'h00, SECT_CNT_M1[15:8]};
        8'h2F:   qry_word = {8'h00, SECT_UNITS[7:0]};
        8'h30:   qry_word = {8'h00, SECT_UNITS[15:8]};
        8'h31:   qry_word = {8'h00, BLK_CNT_M1[7:0]};
        8'h32:   qry_word = {8'h00, BLK_CNT_M1[15:8]};
        8'h33:   qry_word = {8'h00, BLK_UNITS[7:0]};
        8'h34:   qry_word = {8'h00, BLK_UNITS[15:8]};
        default: qry_word = 16'h0000;
      endcase
    end
  end

  always_comb begin
    unique case (rd_mode_i)
      RD_IDENT: begin
        if (rd_addr_i == ADDR_W'(0))      info_data_o = DATA_W'(MFR_CODE);
        else if (rd_addr_i == ADDR_W'(1)) info_data_o = DATA_W'(DEV_CODE);
        else                              info_data_o = '0;
      end
      RD_QUERY: info_data_o = DATA_W'(qry_word);
      default:  info_data_o = '0;
    endcase
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int          ADDR_W     = 20,
  parameter int          DATA_W     = 16,
  parameter int          SECTOR_LSB = 11,
  parameter int          BLOCK_LSB  = 15,
  parameter logic [15:0] MFR_CODE   = 16'h00A7,
  parameter logic [15:0] DEV_CODE   = 16'h3C19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              op_start_o,
  output logic [2:0]        op_type_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic [1:0]        rd_mode_o,
  output logic [DATA_W-1:0] info_data_o
);

  cyc_class_t cls;
  op_type_e   op_type;
  rd_mode_e   rd_mode;

  flash_cmd_match u_match (
    .addr_lo_i (wr_addr_i[CMP_AW-1:0]),
    .data_lo_i (wr_data_i[7:0]),
    .cls_o     (cls)
  );

  flash_cmd_seq #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SECTOR_LSB (SECTOR_LSB),
    .BLOCK_LSB  (BLOCK_LSB)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_valid_i (wr_valid_i),
    .busy_i     (busy_i),
    .cls_i      (cls),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .op_start_o (op_start_o),
    .op_type_o  (op_type),
    .op_addr_o  (op_addr_o),
    .op_data_o  (op_data_o),
    .rd_mode_o  (rd_mode)
  );

  flash_info_rom #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .SECTOR_LSB (SECTOR_LSB),
    .BLOCK_LSB  (BLOCK_LSB),
    .MFR_CODE   (MFR_CODE),
    .DEV_CODE   (DEV_CODE)
  ) u_rom (
    .rd_mode_i   (rd_mode),
    .rd_addr_i   (rd_addr_i),
    .info_data_o (info_data_o)
  );

  assign op_type_o = op_type;
  assign rd_mode_o = rd_mode;

  // R8
  info_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_mode_o == 2'd0) |-> (info_data_o == '0));

  // R7
  mode_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode_o != 2'd3);

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/100ps
module flash_cmd_decoder_test;

  localparam logic [15:0] MFR = 16'h00A7;
  localparam logic [15:0] DEV = 16'h3C19;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [19:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        busy = 1'b0;
  logic [19:0] rd_addr = '0;
  logic        op_start;
  logic [2:0]  op_type;
  logic [19:0] op_addr;
  logic [15:0] op_data;
  logic [1:0]  rd_mode;
  logic [15:0] info_data;

  int checks = 0;
  int errors = 0;
  bit run = 0;
  bit finished = 0;
  string cur_req = "R1";

  // reference state
  int m_step, m_mode, m_type;
  bit m_start;
  logic [19:0] m_addr;
  logic [15:0] m_data;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_valid_i(wr_valid), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .busy_i(busy), .rd_addr_i(rd_addr),
    .op_start_o(op_start), .op_type_o(op_type), .op_addr_o(op_addr),
    .op_data_o(op_data), .rd_mode_o(rd_mode), .info_data_o(info_data)
  );

  function automatic logic [15:0] exp_info(int mode, logic [19:0] a);
    if (mode == 1) return (a == 0) ? MFR : (a == 1) ? DEV : 16'h0;
    if (mode != 2) return 16'h0;
    case (a)
      20'h10: return 16'h0051;
      20'h11: return 16'h0052;
      20'h12: return 16'h0059;
      20'h13: return 16'h0001;
      20'h27: return 16'h0015;
      20'h28: return 16'h0001;
      20'h2C: return 16'h0002;
      20'h2D: return 16'h00FF;
      20'h2E: return 16'h0001;
      20'h2F: return 16'h0010;
      20'h31: return 16'h001F;
      20'h34: return 16'h0001;
      default: return 16'h0;
    endcase
  endfunction

  // behavioural reference, one update per clock
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_step = 0; m_mode = 0; m_start = 0; m_type = 0; m_addr = 0; m_data = 0;
    end else begin
      int a, d;
      bit brk;
      m_start = 0; m_type = 0; m_addr = 0; m_data = 0;
      if (wr_valid && !busy) begin
        a = int'(wr_addr) & 'h7FFF;
        d = int'(wr_data) & 'hFF;
        brk = 0;
        case (m_step)
          0: if (d == 'hF0) m_mode = 0;
             else if (d == 'hAA && a == 'h5555) m_step = 1;
             else brk = 1;
          1: if (d == 'h55 && a == 'h2AAA) m_step = 2; else brk = 1;
          2: begin
            m_step = 0;
            if (a != 'h5555) brk = 1;
            else if (d == 'hA0) m_step = 3;
            else if (d == 'h80) m_step = 4;
            else if (d == 'h90) m_mode = 1;
            else if (d == 'h98) m_mode = 2;
            else if (d == 'hF0) m_mode = 0;
            else brk = 1;
          end
          3: begin
            m_start = 1; m_type = 1; m_addr = wr_addr; m_data = wr_data;
            m_step = 0; m_mode = 0;
          end
          4: if (d == 'hAA && a == 'h5555) m_step = 5; else brk = 1;
          5: if (d == 'h55 && a == 'h2AAA) m_step = 6; else brk = 1;
          default: begin
            if (d == 'h10 && a == 'h5555) begin m_start = 1; m_type = 4; end
            else if (d == 'h30) begin m_start = 1; m_type = 2; m_addr = wr_addr & 20'hFF800; end
            else if (d == 'h50) begin m_start = 1; m_type = 3; m_addr = wr_addr & 20'hF8000; end
            m_step = 0; m_mode = 0;
          end
        endcase
        if (brk) begin m_step = 0; m_mode = 0; end
      end
    end
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (run && rst_n) begin
      chk(cur_req, "op_start", op_start, m_start);
      chk(cur_req, "op_type", op_type, m_type);
      chk(cur_req, "op_addr", op_addr, m_addr);
      chk(cur_req, "op_data", op_data, m_data);
      chk(cur_req, "rd_mode", rd_mode, m_mode);
      chk(cur_req, "info_data", info_data, exp_info(m_mode, rd_addr));
    end
  end

  task automatic wr(logic [19:0] a, logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic unlock();
    wr(20'h05555, 16'h00AA);
    wr(20'h02AAA, 16'h0055);
  endtask

  task automatic erase_pre();
    unlock();
    wr(20'h05555, 16'h0080);
    unlock();
  endtask

  task automatic rd(logic [19:0] a);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state during reset
    chk("R1", "mode in reset", rd_mode, 0);
    chk("R1", "start in reset", op_start, 0);
    chk("R1", "type in reset", op_type, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run = 1;
    repeat (2) @(negedge clk);

    cur_req = "R3";  // program
    unlock(); wr(20'h05555, 16'h00A0); wr(20'h12345, 16'hBEEF);
    cur_req = "R2";  // upper bits are don't-care
    wr(20'hF5555, 16'h12AA); wr(20'hA2AAA, 16'hFF55); wr(20'h35555, 16'h77A0);
    wr(20'hFFFFF, 16'h0001);
    cur_req = "R4";
    erase_pre(); wr(20'h05555, 16'h0010);
    cur_req = "R5";
    erase_pre(); wr(20'h54FFF, 16'h0030);
    cur_req = "R6";
    erase_pre(); wr(20'hABCDE, 16'hAA50);

    cur_req = "R7";
    unlock(); wr(20'h05555, 16'h0090);
    rd(20'h0); rd(20'h1); rd(20'h2); rd(20'h10);
    cur_req = "R9";  // single-write exit at any address
    wr(20'h01234, 16'h00F0);
    rd(20'h0);

    cur_req = "R8";
    unlock(); wr(20'h05555, 16'h0098);
    for (int i = 'h0F; i <= 'h35; i++) rd(20'(i));
    rd(20'h00110);
    cur_req = "R9";  // three-cycle exit
    unlock(); wr(20'h05555, 16'h00F0);
    rd(20'h10);

    cur_req = "R10";
    unlock(); wr(20'h05555, 16'h0090);
    wr(20'h00000, 16'h0000);                       // stray write leaves ident
    wr(20'h05555, 16'h00AA); wr(20'h02AAB, 16'h0055); // bad second cycle
    wr(20'h02AAA, 16'h0055);
    unlock(); wr(20'h05555, 16'h0033);              // unknown third code
    unlock(); wr(20'h04555, 16'h00A0);              // third at wrong address
    wr(20'h00010, 16'h1234);
    erase_pre(); wr(20'h01234, 16'h0010);           // chip code off address
    erase_pre(); wr(20'h05555, 16'h0077);
    unlock(); wr(20'h05555, 16'h0080); wr(20'h05555, 16'h0055);
    wr(20'h05555, 16'h0030);

    cur_req = "R11";
    unlock(); wr(20'h05555, 16'h0090);
    @(negedge clk); busy = 1'b1;
    wr(20'h00000, 16'h00F0);
    unlock(); wr(20'h05555, 16'h00F0);
    unlock(); wr(20'h05555, 16'h00A0); wr(20'h00100, 16'h5A5A);
    rd(20'h1);
    @(negedge clk); busy = 1'b0;
    cur_req = "R9";
    wr(20'h00000, 16'h00F0);

    cur_req = "R13";
    unlock(); wr(20'h05555, 16'h0098);
    rd(20'h11);
    unlock(); wr(20'h05555, 16'h00A0); wr(20'h00011, 16'hC0DE);
    cur_req = "R12";
    erase_pre(); wr(20'h07FFF, 16'h0050);
    wr(20'h05555, 16'h0030);
    repeat (4) @(negedge clk);

    cur_req = "R1";
    unlock(); wr(20'h05555, 16'h0090);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); #1;
    chk("R1", "mode after async reset", rd_mode, 0);
    chk("R1", "start after async reset", op_start, 0);
    rst_n = 1'b1;
    wr(20'h02AAA, 16'h0055);  // sequence must be at its first step
    rd(20'h0);
    repeat (3) @(negedge clk);
    run = 0;
    summary();
  end

endmodule